// File: doc/BRIEF.md
# Bunch Reference Periodicity Checker

The block watches a synchronized bunch-reference pulse that marks the first bunch of every accelerator revolution. It counts system-clock beats from one rising edge of that pulse to the next and rates each edge against a nominal revolution length of `PERIOD` beats (120 by default). Each rating comes out as a one-cycle, 2-bit status code for the downstream capture logic. The block also reports each revolution in which the reference never shows up. Noise can shift or swallow reference pulses, so the capture logic can use these codes to trust or distrust the stored pattern around each revolution boundary.

Alongside the status code, the block keeps a bunch index. The index restarts at zero on every reference edge and otherwise runs freely, wrapping at the end of the revolution. Capture logic can therefore tag each sample with its bunch position even when a reference pulse is lost. There is no data stream through the block, so it has no handshake. All pins are plain control and status signals. Re-synchronizing the raw reference to the system clock is done upstream.

Top module: `fid_period_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `status_o` is 00 and `bunch_o` is 0.
- R2: The first rising edge of `fid_i` after reset is rated 10 (invalid), because no earlier edge exists to measure from.
- R3: A rising edge of `fid_i` sampled exactly `PERIOD` clocks after the previous sampled rising edge is rated 01 (valid), provided no missing report (11) came in between.
- R4: A rising edge sampled fewer than `PERIOD` clocks after the previous one is rated 10.
- R5: Once an edge has been seen, every run of `PERIOD` clocks without a new edge produces one cycle of 11 (missing). The code repeats every `PERIOD` clocks for as long as the reference stays absent.
- R6: The first edge after one or more missing reports is rated 10, even when its spacing is an exact multiple of `PERIOD`.
- R7: A rating (01 or 10) appears for one cycle only, in the cycle after the clock edge at which the rising edge of `fid_i` is sampled. In every cycle with no rating and no missing report, `status_o` is 00.
- R8: `bunch_o` is 0 in the cycle after a sampled rising edge. Otherwise it advances by one per clock and wraps from `PERIOD-1` to 0.
- R9: Only the 0-to-1 transition of `fid_i` is an event. A pulse held high for several clocks counts once, measured from its first high sample.
- R10: Between reset and the first edge, no missing report (11) is produced, however long the reference stays absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fid_i | input | 1 | Synchronized bunch-reference pulse |
| status_o | output | 2 | 00 mid-cycle, 01 valid edge, 10 invalid edge, 11 missing reference |
| bunch_o | output | IDX_W ($clog2(PERIOD)) | Bunch index within the current revolution |

## Verification
The hardest case to reach from the ports is an edge that returns after one or more missing windows. This covers a spacing of exactly twice the period, which must still be rated invalid, and a spacing that spans two missing reports before the edge arrives. A table of edge spacings reaches these cases by holding the reference low for 121, 240 and 250 clocks between edges. While it waits, the bench counts the 11 codes it sees and compares that count with the number of whole periods that have passed. Directed tests then apply reset in the middle of a run and hold the reference low for a long stretch, to show that no 11 appears before the first edge.

// File: rtl/fidchk_pkg.sv
package fidchk_pkg;
  typedef enum logic [1:0] {
    ST_MID  = 2'b00,
    ST_GOOD = 2'b01,
    ST_BAD  = 2'b10,
    ST_LOST = 2'b11
  } fid_status_e;
endpackage

// File: rtl/fidchk_edge.sv
module fidchk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_i;
  end

  assign rise_o = pulse_i & ~pulse_q;
endmodule

// File: rtl/fidchk_beat.sv
module fidchk_beat #(
  parameter int PERIOD = 120,
  parameter int IDX_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             full_o,
  output logic [IDX_W-1:0] bunch_o
);
  localparam int GAP_W = $clog2(PERIOD + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(PERIOD);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PERIOD - 1);

  logic [GAP_W-1:0] gap_q;
  logic [IDX_W-1:0] idx_q;

  assign full_o = (gap_q == GAP_FULL);

  // beats since last edge; restarts on an edge or on a full window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (rise_i || full_o) gap_q <= GAP_W'(1);
    else                       gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (rise_i)           idx_q <= '0;
    else if (idx_q == IDX_LAST) idx_q <= '0;
    else                       idx_q <= idx_q + 1'b1;
  end

  assign bunch_o = idx_q;
endmodule

// File: rtl/fidchk_verdict.sv
module fidchk_verdict
  import fidchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_i,
  input  logic        full_i,
  output fid_status_e status_o
);
  fid_status_e status_q;
  logic        armed_q;
  logic        lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_MID;
      armed_q  <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      status_q <= ST_MID;
      if (rise_i) begin
        status_q <= (armed_q && full_i && !lost_q) ? ST_GOOD : ST_BAD;
        armed_q  <= 1'b1;
        lost_q   <= 1'b0;
      end else if (full_i && armed_q) begin
        status_q <= ST_LOST;
        lost_q   <= 1'b1;
      end
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/fid_period_checker.sv
module fid_period_checker
  import fidchk_pkg::*;
#(
  parameter int PERIOD = 120,
  parameter int IDX_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fid_i,
  output logic [1:0]       status_o,
  output logic [IDX_W-1:0] bunch_o
);
  logic        rise;
  logic        full;
  fid_status_e status;

  fidchk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (fid_i),
    .rise_o  (rise)
  );

  fidchk_beat #(.PERIOD(PERIOD), .IDX_W(IDX_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .full_o  (full),
    .bunch_o (bunch_o)
  );

  fidchk_verdict u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .full_i   (full),
    .status_o (status)
  );

  assign status_o = status;
endmodule

// File: rtl/fid_period_checker_sva.sv
module fid_period_checker_sva #(
  parameter int PERIOD = 120,
  parameter int IDX_W  = $clog2(PERIOD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fid_i,
  input logic [1:0]       status_o,
  input logic [IDX_W-1:0] bunch_o
);
  logic fid_seen_q;
  logic edge_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fid_seen_q <= 1'b0;
    else        fid_seen_q <= fid_i;
  end

  assign edge_now = fid_i && !fid_seen_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (status_o == 2'b00 && bunch_o == '0));

  assert_edge_rated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |=> (status_o == 2'b01 || status_o == 2'b10));

  assert_good_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b01) |-> ($past(bunch_o) == IDX_W'(PERIOD - 1)));

  assert_no_rating_without_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_now |=> (status_o != 2'b01 && status_o != 2'b10));

  assert_index_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |=> (bunch_o == '0));

  assert_index_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_now && bunch_o != IDX_W'(PERIOD - 1)) |=> (bunch_o == $past(bunch_o) + 1'b1));

  assert_index_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_now && bunch_o == IDX_W'(PERIOD - 1)) |=> (bunch_o == '0));
endmodule

bind fid_period_checker fid_period_checker_sva #(.PERIOD(PERIOD), .IDX_W(IDX_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .fid_i    (fid_i),
  .status_o (status_o),
  .bunch_o  (bunch_o)
);

// File: tb/tb_fid_period_checker.sv
`timescale 1ns/1ps
module tb_fid_period_checker;
  localparam int PERIOD = 120;
  localparam int IDX_W  = $clog2(PERIOD);
  localparam int NVEC   = 14;
  localparam int GOOD = 1, BAD = 2, LOST = 3;

  // columns: spacing in clocks, pulse width, expected rating, expected missing reports
  localparam int VEC [NVEC][4] = '{
    '{ 10, 1, BAD,  0},  // R2 first edge
    '{120, 1, GOOD, 0},  // R3
    '{120, 3, GOOD, 0},  // R3 R9 wide pulse
    '{120, 1, GOOD, 0},  // R9 measured from rise
    '{ 50, 1, BAD,  0},  // R4 early
    '{120, 1, GOOD, 0},  // R3 after early
    '{119, 1, BAD,  0},  // R4 one short
    '{121, 1, BAD,  1},  // R5 R6 one late
    '{120, 1, GOOD, 0},  // R3 recovery
    '{250, 2, BAD,  2},  // R5 repeated, R6
    '{240, 1, BAD,  1},  // R6 exact multiple
    '{120, 1, GOOD, 0},  // R3
    '{  2, 1, BAD,  0},  // R4 minimum spacing
    '{120, 5, GOOD, 0}   // R3 R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid_i = 1'b0;
  logic [1:0] status_o;
  logic [IDX_W-1:0] bunch_o;

  int checks = 0;
  int errors = 0;
  int prev_w = 1;
  int cyc = 0;

  always #2 clk = ~clk;

  fid_period_checker #(.PERIOD(PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i), .status_o(status_o), .bunch_o(bunch_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait so the next rise is sampled 'gap' clocks after the previous one, then rate it
  task automatic fire(input int gap, input int width, input int exp, input int exp_lost,
                      input bit armed, input string req);
    int lost = 0;
    int rated = 0;
    for (int j = 1; j < gap; j++) begin
      @(negedge clk);
      if (prev_w >= 2 && j == prev_w - 1) fid_i = 1'b0;
      if (status_o == 2'(LOST)) lost++;
      if (status_o == 2'(GOOD) || status_o == 2'(BAD)) rated++;
      if (j == gap - 1 && armed)
        check(int'(bunch_o) == (gap - 1) % PERIOD, {req, " R8 index before edge"},
              int'(bunch_o), (gap - 1) % PERIOD);
    end
    check(lost == exp_lost, {req, " R5 missing count"}, lost, exp_lost);
    check(rated == 0, {req, " R7 no stray rating"}, rated, 0);
    fid_i = 1'b1;
    @(negedge clk);
    check(int'(status_o) == exp, {req, " rating"}, int'(status_o), exp);
    check(bunch_o == '0, {req, " R8 index restart"}, int'(bunch_o), 0);
    if (width == 1) fid_i = 1'b0;
    prev_w = width;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status_o == 2'b00, "R1 status in reset", int'(status_o), 0);
    check(bunch_o == '0, "R1 index in reset", int'(bunch_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_o == 2'b00, "R1 status after release", int'(status_o), 0);

    for (int v = 0; v < NVEC; v++)
      fire(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v != 0, $sformatf("vec%0d", v));

    // directed: reset in mid-run, then long silence before the first edge (R10)
    @(negedge clk);
    fid_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(status_o == 2'b00 && bunch_o == '0, "R1 mid-run reset", int'(status_o), 0);
    rst_n = 1'b1;
    begin
      int lost = 0;
      int bad_step = 0;
      logic [IDX_W-1:0] prev = bunch_o;
      for (int k = 0; k < 3 * PERIOD; k++) begin
        @(negedge clk);
        if (status_o != 2'b00) lost++;
        if (int'(bunch_o) != (int'(prev) + 1) % PERIOD) bad_step++;
        prev = bunch_o;
      end
      check(lost == 0, "R10 no missing report before first edge", lost, 0);
      check(bad_step == 0, "R8 free-running wrap", bad_step, 0);
    end
    prev_w = 1;
    fire(7, 4, BAD, 0, 1'b0, "R2 first edge after mid-run reset");
    fire(120, 1, GOOD, 0, 1'b1, "R3 R9 after wide first pulse");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule